// File: doc/BRIEF.md
# Dual-Dataflow Systolic Multiply-Accumulate Mesh

This block is a square grid of signed multiply-accumulate cells that evaluates C = A·B + D one beat at a time. Each cell holds one 32-bit stationary value. A per-beat mode bit decides what that value means. In output-stationary operation it is the running sum C(i,j), seeded by a preload. In weight-stationary operation its low byte is the weight B(k,j), and partial sums flow down the columns to the bottom edge.

Cells are grouped into square tiles. A tile is combinational from its top and left edges to its bottom edge. A register stage separates neighbouring tiles, so skew is applied per tile position. Every operand stream and every preload is delayed by the same tile distance, which gives two properties:
- a preload never disturbs a beat that entered earlier;
- a preload can be issued while earlier results are still draining.

The bottom-edge results are re-aligned so that a whole output row leaves in one beat.

Top module: `matrix_mesh`

## Requirements
- R1: The dataflow is chosen per beat by `mode_ws` (0 output-stationary, 1 weight-stationary). Beats and preloads of either mode may be freely interleaved, and the results always match a sequential evaluation in issue order.
- R2: Output-stationary compute (`s_drain`=0). Lane i of `s_a` (bits [i*8+:8], signed) carries A(i,k). Lane j of `s_b` carries B(k,j). The beat adds A(i,k)·B(k,j) to the held C(i,j) with 32-bit wrap and emits nothing.
- R3: Output-stationary drain (`s_drain`=1, `s_row`=r) emits held row r of C. It ignores `s_a` and `s_b` and leaves every held value unchanged.
- R4: Weight-stationary compute carries A(r,k) on lane k of `s_a` and D(r,j) on lane j of `s_b`. It emits lane j = D(r,j) + Σk A(r,k)·W(k,j), where W is the signed low byte of the held value. Held values are unchanged.
- R5: A preload (`ld_valid`=1, `ld_acc`=0) replaces every held value with the sign-extended byte at `ld_mat` bits [(i*N+j)*8+:8].
- R6: An accumulate preload (`ld_acc`=1) adds the sign-extended byte to each held value in output-stationary mode. In weight-stationary mode it leaves the held weights untouched.
- R7: A preload affects only beats issued in later cycles. Beats issued earlier and still in flight use the earlier values.
- R8: A stream beat presented in the same cycle as a preload is dropped. It produces no output and no state change, while the preload still takes effect.
- R9: `out_row` lane j sits at bits [j*32+:32] as a signed value, with all lanes valid in the same beat. `out_valid` pulses once per emitting beat exactly 2·NT cycles after issue (4 by default). Output-stationary compute beats and weight-stationary drain beats emit nothing.
- R10: After reset every held value is 0 and `out_valid` is low.
- R11: A new beat may be issued every cycle, and emitting beats then leave on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ws | input | 1 | Dataflow of the beat or preload this cycle: 0 output-stationary, 1 weight-stationary |
| ld_valid | input | 1 | Preload of the stationary matrix this cycle |
| ld_acc | input | 1 | Preload accumulates instead of replacing |
| ld_mat | input | N*N*8 | Preload matrix, element (i,j) at [(i*N+j)*8+:8] |
| s_valid | input | 1 | Stream beat this cycle |
| s_drain | input | 1 | Beat reads out a held row instead of computing |
| s_row | input | clog2(N) | Row index of a drain beat |
| s_a | input | N*8 | Horizontal operand lanes |
| s_b | input | N*8 | Vertical operand lanes: B row or D row |
| out_valid | output | 1 | Result row present |
| out_row | output | N*32 | Result row, lane j at [j*32+:32] |

## Verification
The hardest case to reach from the ports is a preload that lands while beats on both sides of it are still moving through the skewed tiles. Cells near the top-left corner then already hold the new values while cells near the bottom-right still serve the older beat. The stimulus issues a beat, a preload and another beat on consecutive cycles in both modes. It also runs a long random mix of back-to-back preloads, accumulate preloads, collisions and beats of both modes against a sequential model.

// File: rtl/mmesh_pkg.sv
`timescale 1ns/1ps
package mmesh_pkg;
    localparam int OPW  = 8;
    localparam int ACCW = 32;

    typedef logic signed [OPW-1:0]  op_t;
    typedef logic signed [ACCW-1:0] acc_t;

    // horizontal lane: control travels with the left operand
    typedef struct packed {
        logic vld;
        logic ws;
        logic drn;
        op_t  a;
    } hlane_t;

    // vertical lane: operand / partial sum plus emit flag
    typedef struct packed {
        logic emit;
        acc_t v;
    } vlane_t;

    // per-cell preload slice
    typedef struct packed {
        logic vld;
        logic ws;
        logic acc;
        op_t  d;
    } pload_t;

    function automatic acc_t widen(input op_t x);
        return {{(ACCW-OPW){x[OPW-1]}}, x};
    endfunction

    function automatic acc_t mul(input op_t x, input op_t y);
        logic signed [2*OPW-1:0] p;
        p = x * y;
        return {{(ACCW-2*OPW){p[2*OPW-1]}}, p};
    endfunction
endpackage

// File: rtl/mmesh_delay.sv
`timescale 1ns/1ps
module mmesh_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/mmesh_pe.sv
`timescale 1ns/1ps
module mmesh_pe
    import mmesh_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  hlane_t h,
    input  vlane_t vi,
    input  pload_t pl,
    output vlane_t vo
);
    acc_t st;
    op_t  wgt;
    op_t  bop;
    logic ws_mac, os_mac, os_out;

    assign wgt    = st[OPW-1:0];
    assign bop    = vi.v[OPW-1:0];
    assign ws_mac = h.vld &  h.ws & ~h.drn;
    assign os_mac = h.vld & ~h.ws & ~h.drn;
    assign os_out = h.vld & ~h.ws &  h.drn & h.a[0];

    always_comb begin
        vo.emit = vi.emit;
        vo.v    = vi.v;
        if (ws_mac)      vo.v = vi.v + mul(h.a, wgt);
        else if (os_out) vo.v = vi.v + st;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (pl.vld) begin
            if (!pl.acc)     st <= widen(pl.d);
            else if (!pl.ws) st <= st + widen(pl.d);
        end else if (os_mac) begin
            st <= st + mul(h.a, bop);
        end
    end

    // R4
    ws_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (h.vld && h.ws && !pl.vld) |=> $stable(st));
    // R3
    drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (h.vld && h.drn && !pl.vld) |=> $stable(st));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!h.vld && !pl.vld) |=> $stable(st));
    // R6
    ws_accload_chk: assert property (@(posedge clk) disable iff (rst)
        (pl.vld && pl.ws && pl.acc) |=> $stable(st));
endmodule

// File: rtl/mmesh_tile.sv
`timescale 1ns/1ps
module mmesh_tile
    import mmesh_pkg::*;
#(
    parameter int TR = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  hlane_t [TR-1:0]        h_in,
    input  vlane_t [TR-1:0]        v_in,
    input  pload_t [TR*TR-1:0]     pl_in,
    output vlane_t [TR-1:0]        v_out
);
    vlane_t [TR-1:0] vw [TR+1];

    assign vw[0] = v_in;
    assign v_out = vw[TR];

    for (genvar r = 0; r < TR; r++) begin : g_row
        for (genvar c = 0; c < TR; c++) begin : g_col
            mmesh_pe u_pe (
                .clk (clk),
                .rst (rst),
                .h   (h_in[r]),
                .vi  (vw[r][c]),
                .pl  (pl_in[r*TR+c]),
                .vo  (vw[r+1][c])
            );
        end
    end
endmodule

// File: rtl/matrix_mesh.sv
`timescale 1ns/1ps
module matrix_mesh
    import mmesh_pkg::*;
#(
    parameter int TR = 2,
    parameter int NT = 2,
    localparam int N   = TR * NT,
    localparam int RW  = (N > 1) ? $clog2(N) : 1,
    localparam int LAT = 2 * NT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mode_ws,
    input  logic                  ld_valid,
    input  logic                  ld_acc,
    input  logic [N*N*OPW-1:0]    ld_mat,
    input  logic                  s_valid,
    input  logic                  s_drain,
    input  logic [RW-1:0]         s_row,
    input  logic [N*OPW-1:0]      s_a,
    input  logic [N*OPW-1:0]      s_b,
    output logic                  out_valid,
    output logic [N*ACCW-1:0]     out_row
);
    localparam int HW = $bits(hlane_t) * TR;
    localparam int VW = $bits(vlane_t) * TR;
    localparam int PW = $bits(pload_t) * TR * TR;

    logic             go;
    hlane_t [N-1:0]   hl;
    vlane_t [N-1:0]   vs;
    pload_t [N*N-1:0] plr;
    vlane_t [N-1:0]   bot;
    vlane_t [TR-1:0]  tout [NT][NT];
    logic   [N-1:0]   emits;

    // a beat colliding with a preload is dropped
    assign go = s_valid & ~ld_valid;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            hl[i].vld = go;
            hl[i].ws  = mode_ws;
            hl[i].drn = s_drain;
            hl[i].a   = s_drain ? {{(OPW-1){1'b0}}, (s_row == RW'(i))}
                                : s_a[i*OPW +: OPW];
            vs[i].emit = go & (mode_ws ^ s_drain);
            vs[i].v    = s_drain ? '0 : widen(s_b[i*OPW +: OPW]);
        end
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                plr[i*N+j].vld = ld_valid;
                plr[i*N+j].ws  = mode_ws;
                plr[i*N+j].acc = ld_acc;
                plr[i*N+j].d   = ld_mat[(i*N+j)*OPW +: OPW];
            end
        end
    end

    for (genvar tr = 0; tr < NT; tr++) begin : g_tr
        for (genvar tc = 0; tc < NT; tc++) begin : g_tc
            hlane_t [TR-1:0]    th;
            vlane_t [TR-1:0]    tv;
            pload_t [TR*TR-1:0] tp_raw, tp;

            always_comb begin
                for (int r = 0; r < TR; r++)
                    for (int c = 0; c < TR; c++)
                        tp_raw[r*TR+c] = plr[(tr*TR+r)*N + tc*TR + c];
            end

            mmesh_delay #(.W(HW), .DEPTH(1+tr+tc)) u_hd (
                .clk(clk), .rst(rst), .d(hl[tr*TR +: TR]), .q(th));

            mmesh_delay #(.W(PW), .DEPTH(1+tr+tc)) u_pd (
                .clk(clk), .rst(rst), .d(tp_raw), .q(tp));

            if (tr == 0) begin : g_seed
                mmesh_delay #(.W(VW), .DEPTH(1+tc)) u_vd (
                    .clk(clk), .rst(rst), .d(vs[tc*TR +: TR]), .q(tv));
            end else begin : g_link
                mmesh_delay #(.W(VW), .DEPTH(1)) u_vd (
                    .clk(clk), .rst(rst), .d(tout[tr-1][tc]), .q(tv));
            end

            mmesh_tile #(.TR(TR)) u_tile (
                .clk   (clk),
                .rst   (rst),
                .h_in  (th),
                .v_in  (tv),
                .pl_in (tp),
                .v_out (tout[tr][tc])
            );
        end
    end

    // de-skew: nearer columns wait longer so a row leaves in one beat
    for (genvar tc = 0; tc < NT; tc++) begin : g_dsk
        mmesh_delay #(.W(VW), .DEPTH(NT-tc)) u_dsk (
            .clk(clk), .rst(rst), .d(tout[NT-1][tc]), .q(bot[tc*TR +: TR]));
    end

    always_comb begin
        for (int j = 0; j < N; j++) begin
            emits[j]                = bot[j].emit;
            out_row[j*ACCW +: ACCW] = bot[j].v;
        end
    end
    assign out_valid = |emits;

    // checker state: emitting beats issued but not yet delivered
    logic [7:0] pend;
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= pend + {7'b0, go & (mode_ws ^ s_drain)} - {7'b0, out_valid};
    end

    // R9
    emit_align_chk: assert property (@(posedge clk) disable iff (rst)
        (emits == '0) || (&emits));
    // R9
    no_orphan_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (pend != 8'd0));
    // R11
    pend_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pend <= 8'(LAT));
    // R10
    rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);
endmodule

// File: tb/test_matrix_mesh.sv
`timescale 1ns/1ps
module test_matrix_mesh;
    localparam int TR  = 2;
    localparam int NT  = 2;
    localparam int N   = TR * NT;
    localparam int LAT = 2 * NT;
    localparam int RW  = $clog2(N);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode_ws = 1'b0, ld_valid = 1'b0, ld_acc = 1'b0;
    logic [N*N*8-1:0]  ld_mat = '0;
    logic              s_valid = 1'b0, s_drain = 1'b0;
    logic [RW-1:0]     s_row = '0;
    logic [N*8-1:0]    s_a = '0, s_b = '0;
    logic              out_valid;
    logic [N*32-1:0]   out_row;

    always #2.5 clk = ~clk;

    matrix_mesh #(.TR(TR), .NT(NT)) i_matrix_mesh (
        .clk(clk), .rst(rst), .mode_ws(mode_ws), .ld_valid(ld_valid),
        .ld_acc(ld_acc), .ld_mat(ld_mat), .s_valid(s_valid), .s_drain(s_drain),
        .s_row(s_row), .s_a(s_a), .s_b(s_b), .out_valid(out_valid), .out_row(out_row));

    typedef struct {
        int    due;
        int    v[N];
        string req;
    } exp_t;

    exp_t  q[$];
    int    S[N][N];
    int    D[N][N];
    int    A[N];
    int    B[N];
    int    cyc = 0, nchk = 0, nerr = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int r8();
        return int'($urandom_range(255)) - 128;
    endfunction

    task automatic rnd_d();
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) D[i][j] = r8();
    endtask

    task automatic rnd_ab();
        for (int i = 0; i < N; i++) begin A[i] = r8(); B[i] = r8(); end
    endtask

    task automatic chk_out();
        exp_t e;
        nchk++;
        if (q.size() > 0 && q[0].due == cyc) begin
            e = q.pop_front();
            if (!out_valid) begin
                nerr++;
                $display("FAIL %s: out_valid actual=0 expected=1 at cycle %0d", e.req, cyc);
            end else begin
                for (int j = 0; j < N; j++) begin
                    if ($signed(out_row[j*32 +: 32]) != e.v[j]) begin
                        nerr++;
                        $display("FAIL %s: lane %0d actual=%0d expected=%0d at cycle %0d",
                                 e.req, j, $signed(out_row[j*32 +: 32]), e.v[j], cyc);
                        break;
                    end
                end
            end
        end else if (out_valid) begin
            nerr++;
            $display("FAIL R9 (%s): out_valid actual=1 expected=0 at cycle %0d", cur_req, cyc);
        end
    endtask

    // one cycle: check outputs, drive inputs, advance the sequential model
    task automatic tick(bit lv, bit la, bit sv, bit ws, bit dr, int row);
        exp_t e;
        int   acc;
        @(negedge clk);
        chk_out();
        ld_valid = lv; ld_acc = la; s_valid = sv; mode_ws = ws; s_drain = dr;
        s_row = RW'(row);
        for (int i = 0; i < N; i++) begin
            s_a[i*8 +: 8] = A[i][7:0];
            s_b[i*8 +: 8] = B[i][7:0];
            for (int j = 0; j < N; j++) ld_mat[(i*N+j)*8 +: 8] = D[i][j][7:0];
        end
        if (lv) begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    if (!la)      S[i][j] = D[i][j];
                    else if (!ws) S[i][j] = S[i][j] + D[i][j];
        end
        if (sv && !lv) begin
            e.due = cyc + LAT;
            e.req = cur_req;
            if (!ws && !dr) begin
                for (int i = 0; i < N; i++)
                    for (int j = 0; j < N; j++) S[i][j] = S[i][j] + A[i] * B[j];
            end else if (!ws && dr) begin
                for (int j = 0; j < N; j++) e.v[j] = S[row][j];
                q.push_back(e);
            end else if (ws && !dr) begin
                for (int j = 0; j < N; j++) begin
                    acc = B[j];
                    for (int k = 0; k < N; k++) acc = acc + A[k] * int'(byte'(S[k][j]));
                    e.v[j] = acc;
                end
                q.push_back(e);
            end
        end
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) tick(0, 0, 0, 0, 0, 0);
    endtask

    task automatic drain_all();
        for (int r = 0; r < N; r++) begin rnd_ab(); tick(0, 0, 1, 0, 1, r); end
    endtask

    initial begin
        for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) S[i][j] = 0;
        rnd_d(); rnd_ab();
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R10: quiet output and zero held values after reset
        cur_req = "R10";
        idle(2);
        drain_all();
        idle(LAT + 1);

        // R5 / R2: seed C with D, then four compute beats back to back
        cur_req = "R5";
        rnd_d(); tick(1, 0, 0, 0, 0, 0);
        cur_req = "R2";
        for (int k = 0; k < N; k++) begin rnd_ab(); tick(0, 0, 1, 0, 0, 0); end
        drain_all();
        idle(LAT + 1);

        // R6: output-stationary accumulate preload adds onto held C
        cur_req = "R6";
        rnd_d(); tick(1, 1, 0, 0, 0, 0);
        drain_all();
        // R3: drain ignores s_a/s_b and leaves state; same row twice
        cur_req = "R3";
        rnd_ab(); tick(0, 0, 1, 0, 1, 2);
        rnd_ab(); tick(0, 0, 1, 0, 1, 2);
        idle(LAT + 1);

        // R4: weight-stationary rows
        cur_req = "R4";
        rnd_d(); tick(1, 0, 0, 1, 0, 0);
        for (int r = 0; r < N; r++) begin rnd_ab(); tick(0, 0, 1, 1, 0, 0); end
        idle(LAT + 1);

        // R6: weight-stationary accumulate preload keeps weights
        cur_req = "R6";
        rnd_d(); tick(1, 1, 0, 1, 0, 0);
        for (int r = 0; r < N; r++) begin rnd_ab(); tick(0, 0, 1, 1, 0, 0); end
        idle(LAT + 1);

        // R9: ws drain and os compute beats emit nothing
        cur_req = "R9";
        rnd_ab(); tick(0, 0, 1, 1, 1, 1);
        rnd_ab(); tick(0, 0, 1, 0, 0, 0);
        idle(LAT + 1);

        // R7: preload sandwiched between beats in both modes
        cur_req = "R7";
        rnd_ab(); tick(0, 0, 1, 1, 0, 0);
        rnd_d();  tick(1, 0, 0, 1, 0, 0);
        rnd_ab(); tick(0, 0, 1, 1, 0, 0);
        rnd_ab(); tick(0, 0, 1, 0, 1, 3);
        rnd_d();  tick(1, 0, 0, 0, 0, 0);
        rnd_ab(); tick(0, 0, 1, 0, 1, 3);
        idle(LAT + 1);

        // R8: collisions drop the beat but keep the preload
        cur_req = "R8";
        rnd_d(); rnd_ab(); tick(1, 0, 1, 1, 0, 0);
        rnd_ab(); tick(0, 0, 1, 1, 0, 0);
        rnd_d(); rnd_ab(); tick(1, 0, 1, 0, 0, 0);
        drain_all();
        idle(LAT + 1);

        // R11: sustained one-beat-per-cycle output
        cur_req = "R11";
        rnd_d(); tick(1, 0, 0, 1, 0, 0);
        for (int k = 0; k < 16; k++) begin rnd_ab(); tick(0, 0, 1, 1, 0, 0); end
        idle(LAT + 1);

        // R1: random interleaving of modes, preloads and beats
        cur_req = "R1";
        for (int k = 0; k < 600; k++) begin
            rnd_ab();
            if ($urandom_range(9) == 0) rnd_d();
            tick($urandom_range(7) == 0, $urandom_range(1) == 1,
                 $urandom_range(9) < 7, $urandom_range(1) == 1,
                 $urandom_range(3) == 0, int'($urandom_range(N-1)));
        end
        idle(LAT + 2);

        nchk++;
        if (q.size() != 0) begin
            nerr++;
            $display("FAIL R9: pending results actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL R1: watchdog actual=%0d cycles expected=finished", cyc);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule